// File: doc/BRIEF.md
# Vertical Transfer Pattern Sequencer

This block drives the six vertical transfer clocks of an area image sensor during one readout region. A single programmed pattern is laid down in every line: each output has its own starting level and three toggle offsets, the pattern begins at a programmed pixel of the line and repeats a programmed number of times, with the pattern length as the spacing between repetitions. The repetition count is chosen per line from an odd-line and an even-line value. The pattern itself is the same on both.

Two hold windows can freeze all six outputs at their present level over a span of line pixels, each with its own enable. In the normal mode a new line start cuts off any unfinished pattern and restarts it. In sweep mode the repetitions run on across line boundaries until a new region begins. In multiplier mode each toggle offset is scaled by the pattern length, which stretches long, slow transfer pulses over many repetitions. A done output reports that all repetitions of the current run have finished.

The controller is a four-state machine. IDLE is left only by a restart. WAIT runs until the start pixel. RUN steps through positions and repetitions. DONE holds until the next restart. A restart always goes to DONE when the selected count is zero, to RUN when the start pixel is 0, and to WAIT otherwise. WAIT goes to RUN when the line pixel reaches the start pixel. RUN goes to DONE after the last position of the last repetition.

Top module: `vtp_sequencer`

## Requirements
- R1: From reset until the first restart, `v_out` equals `start_pol` and `done` is low.
- R2: A restart is a cycle with `line_start` high and either `sweep_en` low or `region_start` high. The clock edge that samples it starts pixel 0, and each later edge advances the line pixel by one. The output values for pixel p are visible after the p-th edge following that edge.
- R3: The pattern runs from pixel `pat_start`. At position q of a repetition, where 0 <= q < L and L is `pat_len`, with 0 treated as 1, output c shows `start_pol[c]` XOR the parity of how many of its three toggles (field `[c*12 +: 12]` of `tog1_pos`, `tog2_pos` and `tog3_pos`) are <= q.
- R4: Repetitions follow each other every L pixels. After the last one the outputs return to `start_pol` and `done` is high until the next restart.
- R5: The repetition count is `rep_odd` when `odd_line` is high at the restart and `rep_even` otherwise.
- R6: A count of zero gives no pulses. The outputs stay at `start_pol` and `done` is high from pixel 0.
- R7: While `hold_en[0]` is high and the line pixel lies in [`hold_from[11:0]`, `hold_until[11:0]`), all outputs keep the value they had on the previous pixel. The pattern timing keeps running underneath.
- R8: Window 1 does the same with `hold_en[1]`, `hold_from[23:12]` and `hold_until[23:12]`. A window whose enable is low has no effect.
- R9: With `sweep_en` low, every `line_start` abandons the current run and restarts it.
- R10: With `sweep_en` high, a `line_start` without `region_start` resets only the line pixel. Positions and repetitions continue across the boundary. The start pixel must fall in the first line of the region.
- R11: With `mult_en` high, toggle k of output c takes effect at offset tog*L from the pattern start. For example, toggles 2 and 9 with L=4 switch at offsets 8 and 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Line-start strobe, one cycle |
| region_start | input | 1 | Marks the first line of a region (used in sweep mode) |
| odd_line | input | 1 | High on odd lines |
| sweep_en | input | 1 | Sweep mode enable |
| mult_en | input | 1 | Multiplier mode enable |
| start_pol | input | 6 | Starting level per output |
| tog1_pos | input | 72 | First toggle per output, 12 bits each |
| tog2_pos | input | 72 | Second toggle per output |
| tog3_pos | input | 72 | Third toggle per output |
| pat_start | input | 12 | Line pixel where the pattern begins |
| pat_len | input | 12 | Pattern length in pixels |
| rep_odd | input | 12 | Repetitions on odd lines |
| rep_even | input | 12 | Repetitions on even lines |
| hold_from | input | 24 | Hold window start pixels, two fields |
| hold_until | input | 24 | Hold window end pixels (exclusive) |
| hold_en | input | 2 | Per-window enable |
| v_out | output | 6 | Vertical transfer clocks |
| done | output | 1 | All repetitions finished |

## Verification
All state advances on one register stage. The bench drives inputs just after a falling edge. The values for pixel p are therefore compared at the falling edge that follows the p-th rising edge after the edge that sampled `line_start`. A behavioural model built from pixel and offset integers produces the expected `v_out` and `done` at the same rising edge as the design. Both are compared at every falling edge before any input changes, so a result that arrives one cycle early or late shows up as a mismatch on that pixel.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } vtp_state_e;
endpackage

// File: rtl/vtp_timebase.sv
module vtp_timebase
    import vtp_pkg::*;
#(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          region_start,
    input  logic          sweep_en,
    input  logic          odd_line,
    input  logic [PW-1:0] pat_start,
    input  logic [PW-1:0] pat_len,
    input  logic [PW-1:0] rep_odd,
    input  logic [PW-1:0] rep_even,
    output vtp_state_e    state,
    output logic [PW-1:0] pix,
    output logic [PW-1:0] pos,
    output logic [PW-1:0] rep_idx
);
    localparam logic [PW-1:0] PIX_MAX = '1;

    vtp_state_e    state_n;
    logic [PW-1:0] pix_n, pos_n, rep_n, nrep, nrep_n, len_eff;
    logic          restart;

    assign restart = line_start && (!sweep_en || region_start);
    assign len_eff = (pat_len == '0) ? PW'(1) : pat_len;

    always_comb begin
        state_n = state;
        pix_n   = pix;
        pos_n   = pos;
        rep_n   = rep_idx;
        nrep_n  = nrep;
        if (restart) begin
            pix_n  = '0;
            pos_n  = '0;
            rep_n  = '0;
            nrep_n = odd_line ? rep_odd : rep_even;
            if (nrep_n == '0)           state_n = ST_DONE;
            else if (pat_start == '0)   state_n = ST_RUN;
            else                        state_n = ST_WAIT;
        end else begin
            if (line_start)            pix_n = '0;
            else if (pix != PIX_MAX)   pix_n = pix + 1'b1;
            unique case (state)
                ST_IDLE: ;
                ST_WAIT: begin
                    if (pix_n == pat_start) begin
                        state_n = ST_RUN;
                        pos_n   = '0;
                        rep_n   = '0;
                    end
                end
                ST_RUN: begin
                    if (pos == len_eff - 1'b1) begin
                        if (rep_idx + 1'b1 == nrep) begin
                            state_n = ST_DONE;
                        end else begin
                            rep_n = rep_idx + 1'b1;
                            pos_n = '0;
                        end
                    end else begin
                        pos_n = pos + 1'b1;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pix     <= '0;
            pos     <= '0;
            rep_idx <= '0;
            nrep    <= '0;
        end else begin
            state   <= state_n;
            pix     <= pix_n;
            pos     <= pos_n;
            rep_idx <= rep_n;
            nrep    <= nrep_n;
        end
    end

    // R9: every line start brings the line pixel back to zero
    assert_pix_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (pix == '0));

    // R6: a zero count at restart lands in DONE
    assert_zero_rep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && ((odd_line ? rep_odd : rep_even) == '0)) |=> (state == ST_DONE));

    // R4: DONE persists until a restart
    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !restart) |=> (state == ST_DONE));

    // R4: the last position of a repetition wraps or finishes
    assert_rep_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !restart && pos == len_eff - 1'b1)
            |=> (pos == '0 || state == ST_DONE));
endmodule

// File: rtl/vtp_level.sv
module vtp_level
    import vtp_pkg::*;
#(
    parameter int PW  = 12,
    parameter int NCH = 6
) (
    input  vtp_state_e        state,
    input  logic [PW-1:0]     pos,
    input  logic [PW-1:0]     rep_idx,
    input  logic              mult_en,
    input  logic [NCH-1:0]    start_pol,
    input  logic [NCH*PW-1:0] tog1_pos,
    input  logic [NCH*PW-1:0] tog2_pos,
    input  logic [NCH*PW-1:0] tog3_pos,
    output logic [NCH-1:0]    level
);
    logic [PW-1:0] ref_pt;
    logic          running;

    // In multiplier mode a toggle at tog*L is passed exactly when tog <= repetition index
    assign ref_pt  = mult_en ? rep_idx : pos;
    assign running = (state == ST_RUN);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic passed1, passed2, passed3;
        assign passed1   = (tog1_pos[ch*PW +: PW] <= ref_pt);
        assign passed2   = (tog2_pos[ch*PW +: PW] <= ref_pt);
        assign passed3   = (tog3_pos[ch*PW +: PW] <= ref_pt);
        assign level[ch] = start_pol[ch] ^ (running & (passed1 ^ passed2 ^ passed3));
    end
endmodule

// File: rtl/vtp_hold.sv
module vtp_hold #(
    parameter int PW   = 12,
    parameter int NCH  = 6,
    parameter int NWIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [PW-1:0]      pix,
    input  logic [NWIN*PW-1:0] hold_from,
    input  logic [NWIN*PW-1:0] hold_until,
    input  logic [NWIN-1:0]    hold_en,
    input  logic [NCH-1:0]     level,
    output logic [NCH-1:0]     v_out,
    output logic               holding
);
    logic [NWIN-1:0] in_win;
    logic [NCH-1:0]  held;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign in_win[w] = hold_en[w]
                         && (pix >= hold_from[w*PW +: PW])
                         && (pix <  hold_until[w*PW +: PW]);
    end

    assign holding = active && (|in_win);
    assign v_out   = holding ? held : level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held <= '0;
        else        held <= v_out;
    end

    // R7: inside an enabled window the outputs do not move
    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        holding |-> (v_out == $past(v_out)));
endmodule

// File: rtl/vtp_sequencer.sv
module vtp_sequencer
    import vtp_pkg::*;
#(
    parameter int PW   = 12,
    parameter int NCH  = 6,
    parameter int NWIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               region_start,
    input  logic               odd_line,
    input  logic               sweep_en,
    input  logic               mult_en,
    input  logic [NCH-1:0]     start_pol,
    input  logic [NCH*PW-1:0]  tog1_pos,
    input  logic [NCH*PW-1:0]  tog2_pos,
    input  logic [NCH*PW-1:0]  tog3_pos,
    input  logic [PW-1:0]      pat_start,
    input  logic [PW-1:0]      pat_len,
    input  logic [PW-1:0]      rep_odd,
    input  logic [PW-1:0]      rep_even,
    input  logic [NWIN*PW-1:0] hold_from,
    input  logic [NWIN*PW-1:0] hold_until,
    input  logic [NWIN-1:0]    hold_en,
    output logic [NCH-1:0]     v_out,
    output logic               done
);
    vtp_state_e     state;
    logic [PW-1:0]  pix, pos, rep_idx;
    logic [NCH-1:0] level;
    logic           holding;

    vtp_timebase #(.PW(PW)) u_timebase (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .region_start(region_start), .sweep_en(sweep_en), .odd_line(odd_line),
        .pat_start(pat_start), .pat_len(pat_len), .rep_odd(rep_odd),
        .rep_even(rep_even), .state(state), .pix(pix), .pos(pos),
        .rep_idx(rep_idx)
    );

    vtp_level #(.PW(PW), .NCH(NCH)) u_level (
        .state(state), .pos(pos), .rep_idx(rep_idx), .mult_en(mult_en),
        .start_pol(start_pol), .tog1_pos(tog1_pos), .tog2_pos(tog2_pos),
        .tog3_pos(tog3_pos), .level(level)
    );

    vtp_hold #(.PW(PW), .NCH(NCH), .NWIN(NWIN)) u_hold (
        .clk(clk), .rst_n(rst_n), .active(state != ST_IDLE), .pix(pix),
        .hold_from(hold_from), .hold_until(hold_until), .hold_en(hold_en),
        .level(level), .v_out(v_out), .holding(holding)
    );

    assign done = (state == ST_DONE);

    // R4: once finished and not held, outputs sit at the start polarity
    assert_done_pol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !holding) |-> (v_out == start_pol));

    // R1: before the first restart nothing toggles
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!done && v_out == start_pol));
endmodule

// File: tb/vtp_sequencer_tb.sv
module vtp_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PW  = 12;
    localparam int NCH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0, region_start = 1'b0, odd_line = 1'b0;
    logic sweep_en = 1'b0, mult_en = 1'b0;
    logic [NCH-1:0]    start_pol = 6'b010110;
    logic [NCH*PW-1:0] tog1_pos = '0, tog2_pos = '0, tog3_pos = '0;
    logic [PW-1:0]     pat_start = '0, pat_len = 12'd1, rep_odd = '0, rep_even = '0;
    logic [2*PW-1:0]   hold_from = '0, hold_until = '0;
    logic [1:0]        hold_en = '0;
    logic [NCH-1:0]    v_out;
    logic              done;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    vtp_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .region_start(region_start), .odd_line(odd_line), .sweep_en(sweep_en),
        .mult_en(mult_en), .start_pol(start_pol), .tog1_pos(tog1_pos),
        .tog2_pos(tog2_pos), .tog3_pos(tog3_pos), .pat_start(pat_start),
        .pat_len(pat_len), .rep_odd(rep_odd), .rep_even(rep_even),
        .hold_from(hold_from), .hold_until(hold_until), .hold_en(hold_en),
        .v_out(v_out), .done(done)
    );

    // Behavioural reference: pixel index, offset since restart, divide/modulo
    int       m_pix, m_t, m_n;
    bit       m_started;
    bit [5:0] m_out;
    bit       m_done;

    function automatic int tog_of(input logic [NCH*PW-1:0] v, input int ch);
        return int'(v[ch*PW +: PW]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_started = 0; m_pix = 0; m_t = 0; m_n = 0;
            m_out = start_pol; m_done = 0;
        end else begin
            bit restart, run, frozen;
            int len, k, q, r, x, cnt;
            bit [5:0] lvl;
            restart = line_start && (!sweep_en || region_start);
            if (line_start) m_pix = 0;
            else if (m_pix < 4095) m_pix++;
            if (restart) begin
                m_started = 1; m_t = 0;
                m_n = odd_line ? int'(rep_odd) : int'(rep_even);
            end else if (m_started) m_t++;
            len = (pat_len == 0) ? 1 : int'(pat_len);
            run = 0; m_done = 0; q = 0; r = 0;
            if (m_started) begin
                if (m_n == 0) m_done = 1;
                else if (m_t >= int'(pat_start)) begin
                    k = m_t - int'(pat_start);
                    if (k >= m_n * len) m_done = 1;
                    else begin run = 1; q = k % len; r = k / len; end
                end
            end
            x = mult_en ? r : q;
            for (int c = 0; c < NCH; c++) begin
                cnt = 0;
                if (tog_of(tog1_pos, c) <= x) cnt++;
                if (tog_of(tog2_pos, c) <= x) cnt++;
                if (tog_of(tog3_pos, c) <= x) cnt++;
                lvl[c] = start_pol[c] ^ (run && (cnt % 2 == 1));
            end
            frozen = 0;
            for (int w = 0; w < 2; w++)
                if (hold_en[w] && m_pix >= int'(hold_from[w*PW +: PW])
                               && m_pix <  int'(hold_until[w*PW +: PW]))
                    frozen = m_started;
            if (!frozen) m_out = lvl;
        end
    end

    task automatic cmp();
        checks++;
        if (v_out !== m_out || done !== m_done) begin
            failures++;
            $display("FAIL %s t=%0t v_out=%b done=%b expected v_out=%b done=%b",
                     cur_req, $time, v_out, done, m_out, m_done);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cmp();
    endtask

    task automatic run_line(input bit odd, input bit region, input int cycles);
        line_start = 1'b1; odd_line = odd; region_start = region;
        tick();
        line_start = 1'b0; region_start = 1'b0;
        for (int i = 1; i < cycles; i++) tick();
    endtask

    task automatic set_basic();
        for (int c = 0; c < NCH; c++) begin
            tog1_pos[c*PW +: PW] = PW'(c % 3);
            tog2_pos[c*PW +: PW] = PW'(c % 3 + 2);
            tog3_pos[c*PW +: PW] = (c < 3) ? PW'(5) : PW'(4095);
        end
        pat_start = 12'd3; pat_len = 12'd6;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        set_basic();
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (v_out !== start_pol || done !== 1'b0) begin
                failures++;
                $display("FAIL R1 in reset v_out=%b done=%b expected v_out=%b done=0",
                         v_out, done, start_pol);
            end
        end
        rst_n = 1'b1;
        repeat (5) tick();

        // R2, R3, R4: basic repeats on an odd line
        cur_req = "R3";
        rep_odd = 12'd3; rep_even = 12'd3;
        run_line(1'b1, 1'b0, 40);

        // R5: odd and even counts differ
        cur_req = "R5";
        rep_odd = 12'd2; rep_even = 12'd4;
        run_line(1'b1, 1'b0, 35);
        run_line(1'b0, 1'b0, 35);

        // R6: zero count on an even line
        cur_req = "R6";
        rep_even = 12'd0;
        run_line(1'b0, 1'b0, 20);

        // R7, R8: hold windows
        cur_req = "R7";
        rep_odd = 12'd5;
        hold_from  = {12'd20, 12'd10};
        hold_until = {12'd24, 12'd15};
        hold_en = 2'b11;
        run_line(1'b1, 1'b0, 40);
        cur_req = "R8";
        hold_en = 2'b10;
        run_line(1'b1, 1'b0, 40);
        hold_en = 2'b00;
        run_line(1'b1, 1'b0, 40);

        // R9: line start cuts an unfinished run
        cur_req = "R9";
        rep_odd = 12'd20;
        run_line(1'b1, 1'b0, 15);
        rep_odd = 12'd4;
        run_line(1'b1, 1'b0, 35);

        // R10: sweep across lines, then a new region restarts
        cur_req = "R10";
        sweep_en = 1'b1; rep_odd = 12'd6; rep_even = 12'd6;
        run_line(1'b1, 1'b1, 12);
        run_line(1'b0, 1'b0, 12);
        run_line(1'b1, 1'b0, 12);
        run_line(1'b0, 1'b0, 12);
        run_line(1'b1, 1'b1, 45);
        sweep_en = 1'b0;

        // R11: multiplier mode, toggles 2 and 9 with length 4
        cur_req = "R11";
        mult_en = 1'b1; pat_start = 12'd1; pat_len = 12'd4;
        rep_odd = 12'd9; rep_even = 12'd9;
        for (int c = 0; c < NCH; c++) begin
            tog1_pos[c*PW +: PW] = (c == 0) ? PW'(2) : PW'(c);
            tog2_pos[c*PW +: PW] = (c == 0) ? PW'(9) : PW'(c + 3);
            tog3_pos[c*PW +: PW] = PW'(4095);
        end
        run_line(1'b0, 1'b0, 45);
        mult_en = 1'b0;
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule